// File: doc/BRIEF.md
# Master-slave multi-output PWM timer

This block is a small timer array with one master channel and a parameter-set number of slave channels, from one to seven. All slave outputs share one PWM period. The master is an interval timer. It reloads its period value, counts down, and raises a one-cycle tick each time the period ends. Each slave is a one-shot down-counter. On the master tick it loads its own duty value, drives its output active and counts down. When its counter reaches zero it drops the output, raises its own interrupt pulse, and waits for the next tick.

Software writes the per-channel 16-bit data values through a simple write port. Channel 0 holds the master period and channel k holds the duty of slave k. A written value only reaches a counter at a master tick, so a period and its duties written together take effect together at the next tick. Counting advances only on cycles where the count-clock enable is high. A start bit lets the master run; while it is low the master sends no ticks.

Top module: `msp_timer`

## Requirements
- R1: After a synchronous active-high reset, every irq bit and every pwm_out bit is 0 and stays 0 while start is low.
- R2: With start high, the first enabled cycle raises irq[0] and loads the period value P. After that, irq[0] pulses once every P+1 enabled cycles.
- R3: On cycles with cnt_en low no counter changes, no irq bit is raised and pwm_out holds its value.
- R4: After a master tick, slave k loads its duty value D and holds pwm_out[k-1] high from the next cycle for exactly D enabled cycles, then low.
- R5: When its count reaches zero, slave k raises irq[k] for one enabled cycle. It then holds with its output low and raises no further irq until the next master tick.
- R6: A slave duty value of 0 keeps that output low. The slave interrupt fires on the first enabled cycle after the tick.
- R7: A slave duty value of at least P+1 gives an output that stays high across periods, with no slave interrupt.
- R8: A write with wr_addr 0 sets the master period, and wr_addr k (1..NUM_SLAVES) sets the duty of slave k. Writes to higher addresses are ignored. A written value takes effect only at the next master tick, so an output keeps its old timing for the rest of the current period.
- R9: Driving start low stops further master ticks. Raising it again gives a tick on the next enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; counters advance only when high |
| start | input | 1 | Master run bit |
| wr_en | input | 1 | Data register write strobe |
| wr_addr | input | 3 | Channel select: 0 master, k slave k |
| wr_data | input | 16 | Value written |
| irq | output | NUM_SLAVES+1 | Interrupt pulses; bit 0 master tick, bit k slave k reached zero |
| pwm_out | output | NUM_SLAVES | PWM outputs; bit k-1 belongs to slave k |

## Verification
The hardest situation to reach is a register update that lands in the middle of a period. Here the new period and duties must stay invisible until the next tick, even while a slave's count-to-zero lines up with that tick. A directed sequence writes a new duty and a shorter period in the cycles just after a tick. It then measures the output high time and tick count in the remaining part of the old period and across the following period. Alongside this, a seeded random phase mixes gaps in the count enable, stop and restart of the master, and writes to every address, including unused ones. A cycle-level reference model in the bench checks every output on every cycle.

// File: rtl/msp_pkg.sv
package msp_pkg;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = 3;
    localparam int MAX_SLAVES = 7;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        cnt_t  data;
    } wr_req_t;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_DONE  = 2'd2
    } ch_state_e;

    // true when the next decrement lands on zero (or the count is already zero)
    function automatic logic at_terminal(input cnt_t c);
        return c <= cnt_t'(1);
    endfunction
endpackage

// File: rtl/msp_regfile.sv
module msp_regfile
    import msp_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    output cnt_t [NCH-1:0]   regs
);
    localparam addr_t LAST_CH = addr_t'(NCH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr.en && wr.addr <= LAST_CH) begin
            for (int c = 0; c < NCH; c++) begin
                if (wr.addr == addr_t'(c)) regs[c] <= wr.data;
            end
        end
    end

    AST_WR_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr > LAST_CH) |=> $stable(regs)); // R8
endmodule

// File: rtl/msp_master.sv
module msp_master
    import msp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_en,
    input  logic start,
    input  cnt_t period,
    output logic tick
);
    ch_state_e st;
    cnt_t      cnt;

    always_comb begin
        tick = cnt_en && start &&
               ((st == CH_COUNT && cnt == '0) || st != CH_COUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else if (!start) begin
            st <= CH_IDLE;
        end else if (tick) begin
            st  <= CH_COUNT;
            cnt <= period;
        end else if (cnt_en && st == CH_COUNT) begin
            cnt <= cnt - cnt_t'(1);
        end
    end

    AST_MCNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en) |=> $stable(cnt)); // R3
    AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(period))); // R2
    AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
        (tick && period != '0) |=> !tick); // R2
endmodule

// File: rtl/msp_slave.sv
module msp_slave
    import msp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_en,
    input  logic trig,
    input  cnt_t duty,
    output logic pwm,
    output logic irq
);
    ch_state_e st;
    cnt_t      cnt;

    always_comb begin
        irq = cnt_en && !trig && st == CH_COUNT && at_terminal(cnt);
        pwm = (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else if (trig) begin
            st  <= CH_COUNT;
            cnt <= duty;
        end else if (irq) begin
            st  <= CH_DONE;
            cnt <= '0;
        end else if (cnt_en && st == CH_COUNT) begin
            cnt <= cnt - cnt_t'(1);
        end
    end

    AST_PWM_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
        (trig && duty != '0) |=> pwm); // R4
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (trig && duty == '0) |=> !pwm); // R6
    AST_IRQ_ENDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !pwm); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R5
    AST_SCNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en) |=> $stable(cnt)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st != CH_COUNT) |-> !pwm); // R1
endmodule

// File: rtl/msp_timer.sv
module msp_timer
    import msp_pkg::*;
#(
    parameter int NUM_SLAVES = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cnt_en,
    input  logic                  start,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    output logic [NUM_SLAVES:0]   irq,
    output logic [NUM_SLAVES-1:0] pwm_out
);
    localparam int NCH = NUM_SLAVES + 1;

    wr_req_t          wr;
    cnt_t [NCH-1:0]   regs;
    logic             tick;

    always_comb begin
        wr.en   = wr_en;
        wr.addr = wr_addr;
        wr.data = wr_data;
    end

    msp_regfile #(.NCH(NCH)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs)
    );

    msp_master u_master (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .start  (start),
        .period (regs[0]),
        .tick   (tick)
    );

    assign irq[0] = tick;

    for (genvar s = 1; s <= NUM_SLAVES; s++) begin : g_slave
        msp_slave u_slave (
            .clk    (clk),
            .rst    (rst),
            .cnt_en (cnt_en),
            .trig   (tick),
            .duty   (regs[s]),
            .pwm    (pwm_out[s-1]),
            .irq    (irq[s])
        );
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> cnt_en); // R3
endmodule

// File: tb/msp_timer_bench.sv
module msp_timer_bench;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_en = 1'b0;
    logic start = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NS:0] irq;
    logic [NS-1:0] pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    msp_timer #(.NUM_SLAVES(NS)) u_msp_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .start(start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .pwm_out(pwm_out)
    );

    // reference model built from the requirements
    logic [15:0] rg [0:7];
    bit          m_run;
    logic [15:0] m_cnt;
    bit          s_run [1:NS];
    logic [15:0] s_cnt [1:NS];

    function automatic bit exp_tick();
        return cnt_en && start && (!m_run || m_cnt == 16'd0);
    endfunction

    function automatic bit exp_sirq(int s);
        return cnt_en && !exp_tick() && s_run[s] && s_cnt[s] <= 16'd1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_cnt = '0;
            for (int s = 1; s <= NS; s++) begin s_run[s] = 0; s_cnt[s] = '0; end
            for (int a = 0; a < 8; a++) rg[a] = '0;
        end else begin
            bit t;
            t = exp_tick();
            for (int s = 1; s <= NS; s++) begin
                bit si;
                si = exp_sirq(s);
                if (t) begin s_cnt[s] = rg[s]; s_run[s] = 1; end
                else if (si) begin s_cnt[s] = '0; s_run[s] = 0; end
                else if (cnt_en && s_run[s]) s_cnt[s] = s_cnt[s] - 16'd1;
            end
            if (!start) m_run = 0;
            else if (t) begin m_run = 1; m_cnt = rg[0]; end
            else if (cnt_en && m_run) m_cnt = m_cnt - 16'd1;
            if (wr_en && wr_addr <= 3'(NS)) rg[wr_addr] = wr_data;
        end
    end

    // statistics collected every cycle, before the next rising edge
    int mirq_n;
    int pwm_hi [1:NS];
    int sirq_n [1:NS];

    task automatic clear_stats();
        mirq_n = 0;
        for (int s = 1; s <= NS; s++) begin pwm_hi[s] = 0; sirq_n[s] = 0; end
    endtask

    initial begin
        clear_stats();
        forever begin
            @(negedge clk);
            #5;
            if (!rst) begin
                checks++;
                if (irq[0] !== exp_tick()) begin
                    fails++;
                    $display("FAIL R2 master irq at %0t: got %0b exp %0b", $time, irq[0], exp_tick());
                end
                if (irq[0]) mirq_n++;
                for (int s = 1; s <= NS; s++) begin
                    checks++;
                    if (pwm_out[s-1] !== (s_cnt[s] != 16'd0)) begin
                        fails++;
                        $display("FAIL R4 pwm%0d at %0t: got %0b exp %0b", s, $time, pwm_out[s-1], s_cnt[s] != 16'd0);
                    end
                    checks++;
                    if (irq[s] !== exp_sirq(s)) begin
                        fails++;
                        $display("FAIL R5 slave irq%0d at %0t: got %0b exp %0b", s, $time, irq[s], exp_sirq(s));
                    end
                    if (pwm_out[s-1]) pwm_hi[s]++;
                    if (irq[s]) sirq_n[s]++;
                end
            end
        end
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(int a, int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        int unsigned seed;
        int unsigned r;
        seed = 32'h5EED_1234;
        r = $urandom(seed);
        repeat (4) @(negedge clk);
        rst = 0; cnt_en = 1;
        clear_stats();
        run(10);
        check("R1 master irq after reset", mirq_n, 0);
        for (int s = 1; s <= NS; s++) begin
            check("R1 pwm idle after reset", pwm_hi[s], 0);
            check("R1 slave irq idle after reset", sirq_n[s], 0);
        end

        // P=9, D1=3, D2=0, D3=10 (=P+1)
        write(0, 9); write(1, 3); write(2, 0); write(3, 10);
        start = 1;
        @(negedge clk);
        clear_stats();
        run(30);
        check("R2 ticks in three periods", mirq_n, 3);
        check("R4 pwm1 high time", pwm_hi[1], 9);
        check("R5 slave1 irq count", sirq_n[1], 3);
        check("R6 zero duty stays low", pwm_hi[2], 0);
        check("R6 zero duty irq count", sirq_n[2], 3);
        check("R7 full duty high time", pwm_hi[3], 30);
        check("R7 full duty no irq", sirq_n[3], 0);

        // mid-period update: new D1=6, P=4
        clear_stats();
        write(1, 6); write(0, 4);
        run(7);
        check("R8 old duty kept in current period", pwm_hi[1], 3);
        check("R8 no tick in rest of old period", mirq_n, 0);
        run(1);
        clear_stats();
        write(4, 1);
        run(9);
        check("R8 new period ticks (oor write ignored)", mirq_n, 2);
        check("R8 duty above period gives full output", pwm_hi[1], 10);
        check("R8 oor write leaves slave3", pwm_hi[3], 10);

        // enable held low
        cnt_en = 0;
        clear_stats();
        run(20);
        check("R3 no master irq without enable", mirq_n, 0);
        for (int s = 1; s <= NS; s++) begin
            check("R3 no slave irq without enable", sirq_n[s], 0);
            checks++;
            if (pwm_hi[s] != 0 && pwm_hi[s] != 20) begin
                fails++;
                $display("FAIL R3 pwm%0d moved: got %0d exp 0 or 20", s, pwm_hi[s]);
            end
        end
        cnt_en = 1;

        // stop and restart
        start = 0;
        run(3);
        clear_stats();
        run(20);
        check("R9 no tick while stopped", mirq_n, 0);
        start = 1;
        clear_stats();
        run(1);
        check("R9 tick right on restart", mirq_n, 1);

        // random phase, checked by the per-cycle model
        repeat (3000) begin
            r = $urandom;
            cnt_en = (r % 4) != 0;
            start = ((r >> 4) % 100) != 0;
            if (((r >> 12) % 10) == 0) begin
                wr_en = 1;
                wr_addr = 3'((r >> 16) % 8);
                wr_data = (wr_addr == 3'd0) ? 16'((r >> 20) % 16) : 16'((r >> 20) % 21);
            end else begin
                wr_en = 0;
            end
            @(negedge clk);
        end
        wr_en = 0;
        run(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: got hang exp finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule